// File: doc/BRIEF.md
# Polled Ring Record Writer

This block takes decoded records, each made of seven 64-bit field values and a status word, and writes them into a circular buffer in host memory that software reads by polling. Each record fills one fixed slot of eight quadwords (64 bytes). The seven field values go first, in order. The status quadword goes last, and its top bit is a phase flag. The phase flag starts at 1 and inverts each time the write pointer wraps from the last slot back to slot 0.

Memory starts zeroed, so every slot first reads with phase 0. A consumer keeps its own read index and expected phase. It polls the status quadword of the next slot and treats the slot as new once the phase bit matches what it expects. The status quadword is always written after the seven field quadwords. A matching phase bit therefore means the whole record is already in memory, with no producer pointer to read and no interrupt to take.

Records arrive on a valid/ready handshake. Writes leave on a plain memory-write port: one quadword per cycle, given as byte address, data and a write strobe.

Top module: `rec_ring_writer`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it is released, `rec_ready` is 1 and `mem_wr` is 0. After a reset the slot index is 0 and the phase flag is 1, even if the reset came while a record was being written.
- R2: A record is taken on a clock edge where `rec_valid` and `rec_ready` are both 1. `rec_ready` is 0 on each of the eight write cycles that follow and is 1 again on the cycle after the eighth write.
- R3: The eight writes of a record come on eight consecutive cycles, starting on the cycle right after acceptance, with `mem_wr` high on each. `mem_wr` is low on the cycle after the eighth write.
- R4: Write number b (0 to 7) of a record stored in slot s goes to byte address `ring_base + s*64 + b*8`. `ring_base` must have its low six bits at zero.
- R5: Writes 0 to 6 carry field k = b, taken from `rec_fields[64*k+63 : 64*k]`.
- R6: Write 7 is the status quadword. Its bits 62:0 equal `rec_status[62:0]` and bit 63 is the phase flag.
- R7: The first record after reset goes to slot 0. Each later record goes to the next slot, and the slot after `2**RING_LOG2 - 1` is slot 0. A record is never split across the wrap.
- R8: The phase flag is 1 for every record of the first pass through the ring. It inverts each time the slot index returns from the last slot to 0.
- R9: Changes on `rec_fields`, `rec_status` and `rec_valid` while a record is being written do not affect that record's eight writes.
- R10: While no record is accepted and none is in progress, `mem_wr` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| ring_base | input | ADDR_W | Byte address of slot 0, 64-byte aligned, held stable |
| rec_valid | input | 1 | A record is offered |
| rec_ready | output | 1 | Writer can take a record |
| rec_fields | input | 7*64 | Seven field values, field k in bits 64k+63:64k |
| rec_status | input | 63 | Status bits placed in bits 62:0 of the status quadword |
| mem_wr | output | 1 | Write strobe, one quadword per cycle |
| mem_addr | output | ADDR_W | Byte address of the quadword being written |
| mem_wdata | output | 64 | Quadword being written |

## Verification
A table of records is run back to back for well over two passes around the ring. The table mixes field seeds with status words of all zeros, all ones and alternating bits. All-ones status shows that input bit 63 never leaks into the phase flag. Repeated passes show the phase inverting exactly at each wrap and the slot address folding back to the base. Inputs are scrambled right after each acceptance, which separates a design that captures the record from one that forwards its live inputs. Directed cases cover a long idle stretch with no offered record, and a reset in the middle of a record, which must bring back slot 0 with phase 1.

// File: rtl/rrw_pkg.sv
// Package rrw_pkg
// Shared constants and types for the ring record writer.
// Assumes a fixed record layout: seven field quadwords and one status quadword.
package rrw_pkg;
    localparam int QW_W       = 64;
    localparam int FIELD_CNT  = 7;
    localparam int QW_PER_REC = FIELD_CNT + 1;
    localparam int BEAT_W     = $clog2(QW_PER_REC);
    localparam int QW_SHIFT   = $clog2(QW_W / 8);
    localparam int SLOT_SHIFT = QW_SHIFT + BEAT_W;
    localparam int STAT_W     = QW_W - 1;

    typedef logic [QW_W-1:0] qword_t;

    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_BUSY = 1'b1
    } seq_state_t;

    // Build the status quadword: phase flag on top, status bits below.
    function automatic qword_t make_status(input logic phase, input logic [STAT_W-1:0] bits);
        return {phase, bits};
    endfunction
endpackage

// File: rtl/rrw_beat_seq.sv
// Module rrw_beat_seq
// Steps through the eight quadword beats of one record.
// Assumes start is only raised while idle. It reports busy, the current beat
// number, and a strobe on the final (status) beat.
module rrw_beat_seq
    import rrw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic              busy,
    output logic [BEAT_W-1:0] beat,
    output logic              last
);
    localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(QW_PER_REC - 1);

    seq_state_t state_q;
    logic [BEAT_W-1:0] beat_q;

    // Move between idle and busy and count the beats while busy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
            beat_q  <= '0;
        end else begin
            case (state_q)
                SEQ_IDLE: begin
                    if (start) begin
                        state_q <= SEQ_BUSY;
                        beat_q  <= '0;
                    end
                end
                SEQ_BUSY: begin
                    if (beat_q == LAST_BEAT) begin
                        state_q <= SEQ_IDLE;
                        beat_q  <= '0;
                    end else begin
                        beat_q <= beat_q + 1'b1;
                    end
                end
                default: begin
                    state_q <= SEQ_IDLE;
                    beat_q  <= '0;
                end
            endcase
        end
    end

    // Decode the outputs from the registered state.
    always_comb begin
        busy = (state_q == SEQ_BUSY);
        beat = beat_q;
        last = busy && (beat_q == LAST_BEAT);
    end
endmodule

// File: rtl/rrw_slot_ptr.sv
// Module rrw_slot_ptr
// Holds the ring slot index and the phase flag.
// Assumes a power-of-two ring (SLOT_W >= 1). The flag resets to 1 and inverts
// when the index wraps from the last slot to zero.
module rrw_slot_ptr #(
    parameter int SLOT_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              advance,
    output logic [SLOT_W-1:0] slot,
    output logic              phase
);
    localparam logic [SLOT_W-1:0] TOP_SLOT = {SLOT_W{1'b1}};

    logic [SLOT_W-1:0] slot_q;
    logic              phase_q;

    // Step to the next slot after a record is done, inverting the flag on wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_q  <= '0;
            phase_q <= 1'b1;
        end else if (advance) begin
            if (slot_q == TOP_SLOT) begin
                slot_q  <= '0;
                phase_q <= ~phase_q;
            end else begin
                slot_q <= slot_q + 1'b1;
            end
        end
    end

    // Drive the outputs.
    always_comb begin
        slot  = slot_q;
        phase = phase_q;
    end
endmodule

// File: rtl/rrw_rec_hold.sv
// Module rrw_rec_hold
// Captures one record when it is accepted and picks the quadword for each beat.
// Assumes load is a one-cycle pulse at acceptance. The inputs may change
// freely after that.
module rrw_rec_hold
    import rrw_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      load,
    input  logic [FIELD_CNT*QW_W-1:0] fields_in,
    input  logic [STAT_W-1:0]         status_in,
    input  logic                      phase,
    input  logic [BEAT_W-1:0]         beat,
    output qword_t                    word
);
    qword_t            field_q [FIELD_CNT];
    logic [STAT_W-1:0] status_q;
    qword_t            beat_words [QW_PER_REC];

    // One capture register per field quadword.
    for (genvar k = 0; k < FIELD_CNT; k++) begin : g_field
        // Capture field k when a record is accepted.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                field_q[k] <= '0;
            end else if (load) begin
                field_q[k] <= fields_in[k*QW_W +: QW_W];
            end
        end
        assign beat_words[k] = field_q[k];
    end

    // Capture the status bits when a record is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q <= '0;
        end else if (load) begin
            status_q <= status_in;
        end
    end

    assign beat_words[QW_PER_REC-1] = make_status(phase, status_q);

    // Select the quadword for the current beat.
    always_comb begin
        word = beat_words[beat];
    end
endmodule

// File: rtl/rec_ring_writer.sv
// Module rec_ring_writer
// Writes each accepted record as eight quadwords into one slot of a circular
// buffer: seven field quadwords, then the status quadword carrying the phase
// flag. Assumes ring_base is 64-byte aligned and stable, and that the memory
// takes one write per cycle without stalling.
module rec_ring_writer
    import rrw_pkg::*;
#(
    parameter int RING_LOG2 = 3,
    parameter int ADDR_W    = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [ADDR_W-1:0]         ring_base,
    input  logic                      rec_valid,
    output logic                      rec_ready,
    input  logic [FIELD_CNT*QW_W-1:0] rec_fields,
    input  logic [STAT_W-1:0]         rec_status,
    output logic                      mem_wr,
    output logic [ADDR_W-1:0]         mem_addr,
    output logic [QW_W-1:0]           mem_wdata
);
    localparam int SLOT_W = RING_LOG2;
    localparam int OFS_W  = SLOT_W + SLOT_SHIFT;

    logic              busy;
    logic              last_beat;
    logic              accept;
    logic [BEAT_W-1:0] beat;
    logic [SLOT_W-1:0] slot;
    logic              phase;
    logic [OFS_W-1:0]  offset;
    qword_t            word;

    // Handshake: a record is taken only while no record is being written.
    always_comb begin
        rec_ready = !busy;
        accept    = rec_valid && !busy;
    end

    rrw_beat_seq u_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .start (accept),
        .busy  (busy),
        .beat  (beat),
        .last  (last_beat)
    );

    rrw_slot_ptr #(.SLOT_W(SLOT_W)) u_ptr (
        .clk     (clk),
        .rst_n   (rst_n),
        .advance (last_beat),
        .slot    (slot),
        .phase   (phase)
    );

    rrw_rec_hold u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (accept),
        .fields_in (rec_fields),
        .status_in (rec_status),
        .phase     (phase),
        .beat      (beat),
        .word      (word)
    );

    // Form the byte address from slot and beat, and drive the write port.
    always_comb begin
        offset    = {slot, beat, {QW_SHIFT{1'b0}}};
        mem_addr  = ring_base + ADDR_W'(offset);
        mem_wr    = busy;
        mem_wdata = word;
    end
endmodule

// File: rtl/rrw_checker.sv
// Module rrw_checker
// Watches the ports of rec_ring_writer and checks the handshake, the beat
// ordering, the slot stepping and the phase flag. Assumes ring_base is
// 64-byte aligned.
module rrw_checker #(
    parameter int SLOT_W = 3,
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] ring_base,
    input logic              rec_valid,
    input logic              rec_ready,
    input logic              mem_wr,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              stat_phase
);
    logic              is_status;
    logic [SLOT_W-1:0] cur_slot;
    logic              seen_q;
    logic [SLOT_W-1:0] prev_slot_q;
    logic              prev_phase_q;

    // Decode the beat and slot from the write address.
    always_comb begin
        is_status = mem_wr && (mem_addr[5:3] == 3'd7);
        cur_slot  = SLOT_W'((mem_addr - ring_base) >> 6);
    end

    p_busy_not_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> !rec_ready);

    p_accept_starts_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rec_valid && rec_ready) |=> (mem_wr && mem_addr[5:3] == 3'd0));

    p_beat_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr && mem_addr[5:3] != 3'd7) |=> (mem_wr && mem_addr == $past(mem_addr) + ADDR_W'(8)));

    p_status_last_r6: assert property (@(posedge clk) disable iff (!rst_n)
        is_status |=> (!mem_wr && rec_ready));

    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_wr && !(rec_valid && rec_ready)) |=> !mem_wr);

    // Follow each status write and check the slot step and the phase flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_q       <= 1'b0;
            prev_slot_q  <= '0;
            prev_phase_q <= 1'b1;
        end else if (is_status) begin
            if (!seen_q) begin
                p_first_slot_r7: assert (cur_slot == '0);
                p_first_phase_r8: assert (stat_phase == 1'b1);
            end else begin
                p_slot_next_r7: assert (cur_slot == prev_slot_q + 1'b1);
                p_phase_flip_r8: assert (stat_phase == ((cur_slot == '0) ? ~prev_phase_q : prev_phase_q));
            end
            seen_q       <= 1'b1;
            prev_slot_q  <= cur_slot;
            prev_phase_q <= stat_phase;
        end
    end
endmodule

bind rec_ring_writer rrw_checker #(.SLOT_W(RING_LOG2), .ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ring_base  (ring_base),
    .rec_valid  (rec_valid),
    .rec_ready  (rec_ready),
    .mem_wr     (mem_wr),
    .mem_addr   (mem_addr),
    .stat_phase (mem_wdata[63])
);

// File: tb/rec_ring_writer_tb.sv
// Bench for rec_ring_writer: a table of records run back to back, then
// directed cases for idle and for a reset in the middle of a record.
module rec_ring_writer_tb;
    localparam int CLK_PERIOD = 10;
    localparam int RING_LOG2  = 3;
    localparam int ADDR_W     = 32;
    localparam int SLOTS      = 1 << RING_LOG2;
    localparam int NVEC       = 6;
    localparam logic [ADDR_W-1:0] BASE = 32'h8000_1000;

    localparam logic [63:0] SEED_TAB [NVEC] = '{
        64'h0123_4567_89AB_CDEF, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0000,
        64'hA5A5_5A5A_A5A5_5A5A, 64'h8000_0000_0000_0001, 64'h1357_9BDF_2468_ACE0};
    localparam logic [62:0] STAT_TAB [NVEC] = '{
        63'h0, 63'h7FFF_FFFF_FFFF_FFFF, 63'h2AAA_AAAA_AAAA_AAAA,
        63'h5555_5555_5555_5555, 63'h1, 63'h4000_0000_0000_0000};

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] ring_base = BASE;
    logic              rec_valid = 1'b0;
    logic              rec_ready;
    logic [7*64-1:0]   rec_fields = '0;
    logic [62:0]       rec_status = '0;
    logic              mem_wr;
    logic [ADDR_W-1:0] mem_addr;
    logic [63:0]       mem_wdata;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;
    int exp_slot = 0;
    logic exp_phase = 1'b1;

    always #(CLK_PERIOD/2) clk = ~clk;

    rec_ring_writer #(.RING_LOG2(RING_LOG2), .ADDR_W(ADDR_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .ring_base(ring_base),
        .rec_valid(rec_valid), .rec_ready(rec_ready),
        .rec_fields(rec_fields), .rec_status(rec_status),
        .mem_wr(mem_wr), .mem_addr(mem_addr), .mem_wdata(mem_wdata));

    function automatic logic [63:0] fval(input logic [63:0] seed, input int rec, input int k);
        return seed ^ (64'(rec) * 64'h0001_0000_0100_0001) ^ (64'(k + 1) * 64'h1111_0000_0000_1111);
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Offer one record, scramble the inputs after acceptance (R9), check all eight writes.
    task automatic run_record(input logic [63:0] seed, input logic [62:0] stat, input int rec);
        logic [63:0] exp_w [8];
        while (!rec_ready) @(negedge clk);
        for (int k = 0; k < 7; k++) begin
            exp_w[k] = fval(seed, rec, k);
            rec_fields[k*64 +: 64] = exp_w[k];
        end
        exp_w[7] = {exp_phase, stat};
        rec_status = stat;
        rec_valid = 1'b1;
        @(negedge clk);
        rec_valid = 1'b0;
        rec_fields = ~rec_fields;
        rec_status = ~stat;
        for (int b = 0; b < 8; b++) begin
            logic [ADDR_W-1:0] ea;
            ea = BASE + ADDR_W'(exp_slot * 64 + b * 8);
            chk(mem_wr === 1'b1, "R3 write strobe", 64'(mem_wr), 64'd1);
            chk(mem_addr === ea, "R4 R7 address", 64'(mem_addr), 64'(ea));
            if (b < 7) chk(mem_wdata === exp_w[b], "R5 R9 field data", mem_wdata, exp_w[b]);
            else       chk(mem_wdata === exp_w[b], "R6 R8 status data", mem_wdata, exp_w[b]);
            chk(rec_ready === 1'b0, "R2 ready low while writing", 64'(rec_ready), 64'd0);
            @(negedge clk);
        end
        chk(mem_wr === 1'b0, "R3 strobe low after eighth write", 64'(mem_wr), 64'd0);
        chk(rec_ready === 1'b1, "R2 ready back", 64'(rec_ready), 64'd1);
        exp_slot++;
        if (exp_slot == SLOTS) begin
            exp_slot = 0;
            exp_phase = ~exp_phase;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(rec_ready === 1'b1 && mem_wr === 1'b0, "R1 state during reset", {62'd0, rec_ready, mem_wr}, 64'd2);
        rst_n = 1'b1;
        @(negedge clk);
        chk(rec_ready === 1'b1 && mem_wr === 1'b0, "R1 state after reset", {62'd0, rec_ready, mem_wr}, 64'd2);

        // Table walk: over two and a half passes around the ring (R7, R8).
        for (int i = 0; i < 2 * SLOTS + 4; i++)
            run_record(SEED_TAB[i % NVEC], STAT_TAB[i % NVEC], i);

        // R10: nothing offered, nothing written.
        for (int c = 0; c < 6; c++) begin
            chk(mem_wr === 1'b0, "R10 idle no write", 64'(mem_wr), 64'd0);
            @(negedge clk);
        end

        // R1: reset while a record is in flight.
        rec_fields = '1;
        rec_status = 63'h1234;
        rec_valid = 1'b1;
        @(negedge clk);
        rec_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(mem_wr === 1'b0 && rec_ready === 1'b1, "R1 reset mid record", {62'd0, rec_ready, mem_wr}, 64'd2);
        rst_n = 1'b1;
        exp_slot = 0;
        exp_phase = 1'b1;
        @(negedge clk);
        run_record(64'hDEAD_BEEF_0000_0001, 63'h0F0F, 99);
        run_record(64'h0BAD_F00D_0000_0002, 63'h7FFF_FFFF_FFFF_FFFF, 100);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule